// File: doc/BRIEF.md
# Console Terminal Register Port

This block is the processor-side face of a console terminal. Software sees four 16-bit registers on a small register bus: a receive status word, a receive data word, a transmit status word and a transmit data word. Characters arrive from a serial front end over a one-cycle valid strobe and are held in the receive data word, together with error flags. Characters written by software are offered to the front end over a valid/ready handshake. Each direction has its own completion flag and its own interrupt request.

A transmit write does not always carry a character. Its unit-select field (bits 11:8) picks what the write means. A zero select sends the low byte as a character. A select of 0xF runs a console control command coded in the low byte. Two of these commands, software done and reboot request, come out as single-cycle pulses. The two start-flag clears are accepted and do nothing. Every transmit write, whatever its kind, finishes by setting the transmit completion flag after a programmable number of clock cycles.

The register select codes are 0 for receive status, 1 for receive data, 2 for transmit status and 3 for transmit data. The transmit data word reads as zero.

Top module: `con_term_port`

## Requirements
- R1: After reset the receive status reads 0x0000, the transmit status reads 0x0080 (completion set), the receive data reads 0x0000, and both interrupt requests are low.
- R2: A status word shows the completion flag in bit 7 and the interrupt enable in bit 6. Every other bit reads zero, whatever was written. Only bit 6 is writable.
- R3: A status write with bit 6 clear drops that side's interrupt request. A status write with bit 6 set, when completion is set and the enable was clear, raises the request in the next cycle.
- R4: A received character appears in bits 7:0 of the receive data word, sets receive completion, and raises the receive request if the enable is set.
- R5: A bus read of the receive data word returns the full word. It then clears receive completion, clears bits 15:8 while keeping bits 7:0, and drops the receive request.
- R6: A received break loads 0xA000 (summary error in bit 15, framing error in bit 13, character zero).
- R7: A character that arrives while receive completion is still set loads the new character with bit 14 (overrun) and bit 15 (summary error) set.
- R8: A transmit write with select 0 clears transmit completion and its request. It holds `tx_valid` high with the character stable until `tx_ready` is seen. Completion returns exactly TX_DELAY+1 cycles after the handshake edge, with a request if the enable is set.
- R9: A transmit write with select 0xF and low byte 1 gives a one-cycle `swdone_pulse` in the cycle after the write. Low byte 2 gives a one-cycle `reboot_pulse`. Low bytes 3 and 4 give no pulse. No character is offered, and completion returns TX_DELAY+1 cycles after the write edge.
- R10: A transmit write with a select other than 0 or 0xF offers no character and gives no pulse. Completion still returns TX_DELAY+1 cycles after the write edge.
- R11: If a receive data read and a new character fall in the same cycle, the new character is kept without overrun and receive completion stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select (0 rx status, 1 rx data, 2 tx status, 3 tx data) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect on rx data only) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| rx_valid | input | 1 | One-cycle strobe: a character or break arrived |
| rx_char | input | 8 | Received character |
| rx_break | input | 1 | The arrival is a break condition |
| tx_valid | output | 1 | A character is offered to the front end |
| tx_data | output | 8 | Offered character |
| tx_ready | input | 1 | Front end accepts the offered character |
| swdone_pulse | output | 1 | Software-done command pulse |
| reboot_pulse | output | 1 | Reboot-request command pulse |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with TX_DELAY set to 5. With that value it can step cycle by cycle through each completion window and check that the flag is still clear one cycle before the expected edge and set on it. It does this both for a character held back by the front end and for each class of control command. The short delay also leaves room to line a receive read up with a new arrival in the same cycle and to stack two arrivals for the overrun case.

// File: rtl/conterm_pkg.sv
package conterm_pkg;

    localparam int WORD_W   = 16;
    localparam int CHAR_W   = 8;
    localparam int BIT_DONE = 7;
    localparam int BIT_IE   = 6;
    localparam int BIT_ERR  = 15;
    localparam int BIT_OVR  = 14;
    localparam int BIT_FRM  = 13;

    typedef enum logic [1:0] {
        SEL_RX_STAT = 2'd0,
        SEL_RX_DATA = 2'd1,
        SEL_TX_STAT = 2'd2,
        SEL_TX_DATA = 2'd3
    } reg_sel_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND,
        TX_WAIT
    } tx_state_t;

    typedef enum logic [1:0] {
        CMD_CHAR,
        CMD_SWDONE,
        CMD_REBOOT,
        CMD_NOP
    } tx_cmd_t;

    typedef struct packed {
        logic              err;
        logic              ovr;
        logic              frm;
        logic [4:0]        zero;
        logic [CHAR_W-1:0] ch;
    } rx_word_t;

    function automatic tx_cmd_t decode_tx(input logic [WORD_W-1:0] w);
        tx_cmd_t k;
        if (w[11:8] == 4'h0) begin
            k = CMD_CHAR;
        end else if (w[11:8] == 4'hF) begin
            case (w[7:0])
                8'h01:   k = CMD_SWDONE;
                8'h02:   k = CMD_REBOOT;
                default: k = CMD_NOP;
            endcase
        end else begin
            k = CMD_NOP;
        end
        return k;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input logic done, input logic ie);
        logic [WORD_W-1:0] s;
        s = '0;
        s[BIT_DONE] = done;
        s[BIT_IE]   = ie;
        return s;
    endfunction

endpackage

// File: rtl/con_side_flags.sv
module con_side_flags #(
    parameter bit DONE_AT_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_stat,
    input  logic wr_ie,
    input  logic set_done,
    input  logic clr_done,
    output logic done,
    output logic ie,
    output logic irq
);
    logic done_n, ie_n, irq_n;

    always_comb begin
        done_n = done;
        ie_n   = ie;
        irq_n  = irq;
        if (wr_stat) begin
            ie_n = wr_ie;
            if (!wr_ie)
                irq_n = 1'b0;
            else if (done && !ie)
                irq_n = 1'b1;
        end
        if (clr_done) begin
            done_n = 1'b0;
            irq_n  = 1'b0;
        end
        if (set_done) begin
            done_n = 1'b1;
            if (ie_n)
                irq_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= DONE_AT_RESET;
            ie   <= 1'b0;
            irq  <= 1'b0;
        end else begin
            done <= done_n;
            ie   <= ie_n;
            irq  <= irq_n;
        end
    end

    // R3: a request never stands without completion and enable
    assert_irq_needs_done_ie_R3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done && ie));

    // R5 / R8: a clear that no set overrides leaves flag and request low
    assert_clear_drops_done_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_done && !set_done) |=> (!done && !irq));

    // R4: completion with the enable on raises the request
    assert_set_raises_irq_R4: assert property (@(posedge clk) disable iff (rst)
        (set_done && !wr_stat && ie) |=> irq);

endmodule

// File: rtl/con_rx_buf.sv
module con_rx_buf
    import conterm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_break,
    input  logic              done,
    input  logic              rd_clr,
    output logic [WORD_W-1:0] word
);
    rx_word_t buf_q;
    rx_word_t incoming;
    logic     overrun;

    assign overrun = done && !rd_clr;

    always_comb begin
        incoming      = '0;
        incoming.ovr  = overrun;
        incoming.frm  = rx_break;
        incoming.err  = rx_break || overrun;
        incoming.ch   = rx_break ? '0 : rx_char;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
        end else if (rx_valid) begin
            buf_q <= incoming;
        end else if (rd_clr) begin
            buf_q.err  <= 1'b0;
            buf_q.ovr  <= 1'b0;
            buf_q.frm  <= 1'b0;
            buf_q.zero <= '0;
        end
    end

    assign word = buf_q;

    // R7: arrival on top of an unread character flags overrun
    assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && done && !rd_clr) |=> (word[BIT_OVR] && word[BIT_ERR]));

    // R6: a break loads error and framing with a zero character
    assert_break_word_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_break) |=> (word[BIT_ERR] && word[BIT_FRM] && word[7:0] == 8'h00));

    // R5: a read with no arrival leaves only the character
    assert_read_strips_errors_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !rx_valid) |=> (word[15:8] == 8'h00 && $stable(word[7:0])));

endmodule

// File: rtl/con_tx_ctrl.sv
module con_tx_ctrl
    import conterm_pkg::*;
#(
    parameter int TX_DELAY = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] wdata,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    output logic              swdone_pulse,
    output logic              reboot_pulse,
    output logic              fin
);
    localparam int CNT_W = $clog2(TX_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TX_DELAY);

    tx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    tx_cmd_t           cmd;

    assign cmd = decode_tx(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= TX_IDLE;
            cnt          <= '0;
            tx_data      <= '0;
            swdone_pulse <= 1'b0;
            reboot_pulse <= 1'b0;
        end else begin
            swdone_pulse <= 1'b0;
            reboot_pulse <= 1'b0;
            if (start) begin
                if (cmd == CMD_CHAR) begin
                    state   <= TX_SEND;
                    tx_data <= wdata[CHAR_W-1:0];
                end else begin
                    state        <= TX_WAIT;
                    cnt          <= CNT_LOAD;
                    swdone_pulse <= (cmd == CMD_SWDONE);
                    reboot_pulse <= (cmd == CMD_REBOOT);
                end
            end else begin
                case (state)
                    TX_SEND: begin
                        if (tx_ready) begin
                            state <= TX_WAIT;
                            cnt   <= CNT_LOAD;
                        end
                    end
                    TX_WAIT: begin
                        if (cnt == '0)
                            state <= TX_IDLE;
                        else
                            cnt <= cnt - 1'b1;
                    end
                    default: state <= TX_IDLE;
                endcase
            end
        end
    end

    assign tx_valid = (state == TX_SEND);
    assign fin      = (state == TX_WAIT) && (cnt == '0);

    // R8: the offered character stays put until accepted
    assert_offer_held_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !start) |=> (tx_valid && $stable(tx_data)));

    // R9: at most one command pulse at a time
    assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({swdone_pulse, reboot_pulse}));

    // R9: a pulse lasts a single cycle unless a new command follows
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
        ((swdone_pulse || reboot_pulse) && !start) |=> !(swdone_pulse || reboot_pulse));

    // R10: a command never offers a character
    assert_cmd_no_offer_R10: assert property (@(posedge clk) disable iff (rst)
        (start && wdata[11:8] != 4'h0) |=> !tx_valid);

endmodule

// File: rtl/con_term_port.sv
module con_term_port
    import conterm_pkg::*;
#(
    parameter int TX_DELAY = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_char,
    input  logic        rx_break,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        swdone_pulse,
    output logic        reboot_pulse,
    output logic        rx_irq,
    output logic        tx_irq
);
    reg_sel_t          sel;
    logic              rx_stat_wr, tx_stat_wr, tx_data_wr, rx_data_rd;
    logic              rx_done, rx_ie, tx_done, tx_ie;
    logic              tx_fin;
    logic [WORD_W-1:0] rx_word;

    assign sel        = reg_sel_t'(reg_sel);
    assign rx_stat_wr = reg_wr && (sel == SEL_RX_STAT);
    assign tx_stat_wr = reg_wr && (sel == SEL_TX_STAT);
    assign tx_data_wr = reg_wr && (sel == SEL_TX_DATA);
    assign rx_data_rd = reg_rd && (sel == SEL_RX_DATA);

    con_side_flags #(.DONE_AT_RESET(1'b0)) u_rx_flags (
        .clk      (clk),
        .rst      (rst),
        .wr_stat  (rx_stat_wr),
        .wr_ie    (reg_wdata[BIT_IE]),
        .set_done (rx_valid),
        .clr_done (rx_data_rd),
        .done     (rx_done),
        .ie       (rx_ie),
        .irq      (rx_irq)
    );

    con_side_flags #(.DONE_AT_RESET(1'b1)) u_tx_flags (
        .clk      (clk),
        .rst      (rst),
        .wr_stat  (tx_stat_wr),
        .wr_ie    (reg_wdata[BIT_IE]),
        .set_done (tx_fin && !tx_data_wr),
        .clr_done (tx_data_wr),
        .done     (tx_done),
        .ie       (tx_ie),
        .irq      (tx_irq)
    );

    con_rx_buf u_rx_buf (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_char  (rx_char),
        .rx_break (rx_break),
        .done     (rx_done),
        .rd_clr   (rx_data_rd),
        .word     (rx_word)
    );

    con_tx_ctrl #(.TX_DELAY(TX_DELAY)) u_tx_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (tx_data_wr),
        .wdata        (reg_wdata),
        .tx_ready     (tx_ready),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .swdone_pulse (swdone_pulse),
        .reboot_pulse (reboot_pulse),
        .fin          (tx_fin)
    );

    always_comb begin
        case (sel)
            SEL_RX_STAT: reg_rdata = status_word(rx_done, rx_ie);
            SEL_RX_DATA: reg_rdata = rx_word;
            SEL_TX_STAT: reg_rdata = status_word(tx_done, tx_ie);
            default:     reg_rdata = '0;
        endcase
    end

    // R8: a character write drops transmit completion next cycle
    assert_txwrite_clears_R8: assert property (@(posedge clk) disable iff (rst)
        tx_data_wr |=> (!tx_done && !tx_irq));

    // R11: an arrival always leaves receive completion set
    assert_arrival_sets_done_R11: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> rx_done);

endmodule

// File: tb/con_term_port_test.sv
module con_term_port_test;
    localparam int TXD = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        rx_break = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        swdone_pulse, reboot_pulse, rx_irq, tx_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    con_term_port #(.TX_DELAY(TXD)) uut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_char(rx_char), .rx_break(rx_break), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .swdone_pulse(swdone_pulse), .reboot_pulse(reboot_pulse),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] s, input logic [15:0] d);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] s, output logic [15:0] v);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [15:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic rx_send(input logic [7:0] c, input logic brk);
        rx_valid = 1'b1; rx_char = c; rx_break = brk;
        @(negedge clk);
        rx_valid = 1'b0; rx_break = 1'b0;
    endtask

    // counts edges from the current position to transmit completion
    task automatic wait_done_exact(input string tag, input int already);
        logic [15:0] v;
        repeat (TXD - already) step();
        peek(2'd2, v);
        check({tag, " done still clear"}, {15'd0, v[7]}, 16'd0);
        step();
        peek(2'd2, v);
        check({tag, " done set on time"}, {15'd0, v[7]}, 16'd1);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(2'd0, v); check("R1 rx status", v, 16'h0000);
        peek(2'd2, v); check("R1 tx status", v, 16'h0080);
        peek(2'd1, v); check("R1 rx data", v, 16'h0000);
        check("R1 irqs", {14'd0, rx_irq, tx_irq}, 16'd0);
    endtask

    task automatic t_status_bits();
        logic [15:0] v;
        bus_write(2'd0, 16'hFFFF);
        peek(2'd0, v); check("R2 rx status mask", v, 16'h0040);
        check("R3 rx irq stays low without done", {15'd0, rx_irq}, 16'd0);
        bus_write(2'd2, 16'hFFFF);
        peek(2'd2, v); check("R2 tx status mask", v, 16'h00C0);
        check("R3 late enable raises tx irq", {15'd0, tx_irq}, 16'd1);
        bus_write(2'd2, 16'h0000);
        check("R3 enable clear drops tx irq", {15'd0, tx_irq}, 16'd0);
        bus_write(2'd0, 16'h0000);
    endtask

    task automatic t_rx_basic();
        logic [15:0] v;
        bus_write(2'd0, 16'h0040);
        rx_send(8'h41, 1'b0);
        peek(2'd0, v); check("R4 rx done", v, 16'h00C0);
        check("R4 rx irq", {15'd0, rx_irq}, 16'd1);
        peek(2'd1, v); check("R4 rx data", v, 16'h0041);
        bus_read(2'd1, v); check("R5 read returns word", v, 16'h0041);
        peek(2'd0, v); check("R5 read clears done", v, 16'h0040);
        check("R5 read drops irq", {15'd0, rx_irq}, 16'd0);
    endtask

    task automatic t_overrun();
        logic [15:0] v;
        rx_send(8'h31, 1'b0);
        rx_send(8'h32, 1'b0);
        peek(2'd1, v); check("R7 overrun word", v, 16'hC032);
        bus_read(2'd1, v); check("R7 read overrun word", v, 16'hC032);
        peek(2'd1, v); check("R5 errors cleared char kept", v, 16'h0032);
    endtask

    task automatic t_break();
        logic [15:0] v;
        rx_send(8'h77, 1'b1);
        peek(2'd1, v); check("R6 break word", v, 16'hA000);
        bus_read(2'd1, v);
        peek(2'd1, v); check("R6 break cleared", v, 16'h0000);
    endtask

    task automatic t_late_enable();
        logic [15:0] v;
        bus_write(2'd0, 16'h0000);
        rx_send(8'h55, 1'b0);
        check("R4 no irq with enable off", {15'd0, rx_irq}, 16'd0);
        bus_write(2'd0, 16'h0040);
        check("R3 late enable raises rx irq", {15'd0, rx_irq}, 16'd1);
        bus_write(2'd0, 16'h0000);
        check("R3 enable clear drops rx irq", {15'd0, rx_irq}, 16'd0);
        bus_read(2'd1, v);
    endtask

    task automatic t_read_collide();
        logic [15:0] v;
        rx_send(8'h11, 1'b0);
        rx_valid = 1'b1; rx_char = 8'h22; reg_sel = 2'd1; reg_rd = 1'b1;
        #1 v = reg_rdata;
        check("R11 collide read sees old", v, 16'h0011);
        @(negedge clk);
        rx_valid = 1'b0; reg_rd = 1'b0;
        peek(2'd0, v); check("R11 done stays set", {15'd0, v[7]}, 16'd1);
        peek(2'd1, v); check("R11 new char no overrun", v, 16'h0022);
        bus_read(2'd1, v);
    endtask

    task automatic t_tx_char();
        logic [15:0] v;
        tx_ready = 1'b0;
        bus_write(2'd2, 16'h0040);
        check("R3 enable with done raises tx irq", {15'd0, tx_irq}, 16'd1);
        bus_write(2'd3, 16'h0048);
        peek(2'd2, v); check("R8 write clears done", v, 16'h0040);
        check("R8 write drops irq", {15'd0, tx_irq}, 16'd0);
        check("R8 offer valid", {15'd0, tx_valid}, 16'd1);
        check("R8 offer data", {8'd0, tx_data}, 16'h0048);
        repeat (3) step();
        check("R8 offer held", {7'd0, tx_valid, tx_data}, 16'h0148);
        tx_ready = 1'b1;
        step();
        tx_ready = 1'b0;
        check("R8 offer gone after accept", {15'd0, tx_valid}, 16'd0);
        wait_done_exact("R8 char", 0);
        check("R8 completion irq", {15'd0, tx_irq}, 16'd1);
    endtask

    task automatic t_tx_cmd(input logic [15:0] w, input logic sw, input logic rb, input string tag);
        bus_write(2'd3, w);
        check({tag, " pulses"}, {14'd0, swdone_pulse, reboot_pulse}, {14'd0, sw, rb});
        check({tag, " no offer"}, {15'd0, tx_valid}, 16'd0);
        check({tag, " irq dropped"}, {15'd0, tx_irq}, 16'd0);
        step();
        check({tag, " pulse ends"}, {14'd0, swdone_pulse, reboot_pulse}, 16'd0);
        check({tag, " still no offer"}, {15'd0, tx_valid}, 16'd0);
        wait_done_exact(tag, 1);
        check({tag, " completion irq"}, {15'd0, tx_irq}, 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_status_bits();
        t_rx_basic();
        t_overrun();
        t_break();
        t_late_enable();
        t_read_collide();
        t_tx_char();
        t_tx_cmd(16'h0F01, 1'b1, 1'b0, "R9 swdone");
        t_tx_cmd(16'h0F02, 1'b0, 1'b1, "R9 reboot");
        t_tx_cmd(16'h0F03, 1'b0, 1'b0, "R9 clear warm");
        t_tx_cmd(16'h0F04, 1'b0, 1'b0, "R9 clear cold");
        t_tx_cmd(16'h0301, 1'b0, 1'b0, "R10 other select");
        bus_write(2'd2, 16'h0000);
        check("R3 final tx irq drop", {15'd0, tx_irq}, 16'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule